// File: doc/BRIEF.md
# SPI Byte Queue Status and Interrupt Unit

This unit sits between the register bus of a serial peripheral and its shift engine. It keeps two small byte queues. Software writes the transmit queue, and the engine drains it. The engine fills the receive queue, and software reads it. The unit shows both fill levels in one status word and records overflow and underflow events. It also raises a byte-count interrupt, which counts either transmitted or received bytes depending on a mode input. Each event flag stays set until software reads the status word.

In half-word transfer mode, each data access moves two bytes. The low byte is the earlier byte in queue order. In byte mode, one byte moves per access and the upper half of read data is zero. Each queue has a flush control. Flush empties the queue, and while flush is held, the queue's error event does not reach the interrupt.

Top module: `spi_fifo_stat`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty, every status bit reads 0 and `irq_o` is low.
- R2: The `reg_sel` codes are 0 for status, 1 for receive data and 2 for transmit data. In byte mode, a transmit write queues `wdata[7:0]`. A write to a full queue is dropped. The engine receives bytes in write order. The status word shows the transmit level in bits [3:1], encoded 0 to 4.
- R3: If the engine pushes a byte while the receive queue holds 4 bytes, the byte is dropped and status bit 7 is set. Unless receive flush is high, bit 0 is also set.
- R4: If a transfer starts while the transmit queue is empty, status bit 4 is set. Unless transmit flush is high, bit 0 is also set.
- R5: A flush input empties its queue on the next clock. While transmit flush is high, an underflow sets bit 4 but leaves bit 0 and `irq_o` low.
- R6: When `irq_on_tx` is 0 and half-word mode is off, status bit 6 and bit 0 are set once `irq_cnt`+1 bytes have been accepted into the receive queue. The count then restarts.
- R7: When `irq_on_tx` is 1 and half-word mode is off, status bit 5 and bit 0 are set once `irq_cnt`+1 bytes have been popped by the engine. The count then restarts.
- R8: A status read returns the current flags and clears bits 7, 6, 5, 4 and 0 at that clock. The level fields [10:8] and [3:1] are not changed by the read.
- R9: With `dma_en` high, a transmit write queues `wdata[7:0]` and then `wdata[15:8]`. A receive read returns the first byte in [7:0] and the second in [15:8], and removes both. Neither byte-count interrupt is raised in this mode.
- R10: In byte mode, a receive read returns the oldest byte in [7:0] with [15:8] zero, and removes one byte.
- R11: `irq_o` mirrors status bit 0. It only rises in a clock where an overflow, underflow or byte-count flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects at the clock) |
| reg_sel | input | 2 | Register select: 0 status, 1 receive data, 2 transmit data |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle `reg_rd` is high |
| dma_en | input | 1 | Half-word transfer mode |
| rx_flush | input | 1 | Empty the receive queue; mask its overflow interrupt |
| tx_flush | input | 1 | Empty the transmit queue; mask its underflow interrupt |
| irq_on_tx | input | 1 | Byte-count interrupt source: 1 transmit, 0 receive |
| irq_cnt | input | 2 | Byte-count interrupt threshold minus one |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_byte | output | 8 | Head of the transmit queue (0 when empty) |
| eng_start | input | 1 | Engine begins a transfer |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a byte-count interrupt landing together with an overflow. The receive counter has to reach its threshold exactly as the queue fills, and the next push must then be refused. The stimulus sets the threshold to four bytes and pushes five bytes with no reads in between. The status word is read once after the fourth push and once after the fifth. This checks that the refused byte neither advances the counter nor disturbs the stored order.

// File: rtl/spi_fs_pkg.sv
// Shared types for the SPI byte-queue status unit.
// Assumes 4-entry queues so each fill level fits a 3-bit field.
package spi_fs_pkg;
    localparam int LVL_W = 3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_RXDATA = 2'd1,
        SEL_TXDATA = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [4:0]       rsvd;
        logic [LVL_W-1:0] rx_lvl;
        logic             rx_ovf;
        logic             rx_irq;
        logic             tx_irq;
        logic             tx_unf;
        logic [LVL_W-1:0] tx_lvl;
        logic             any_irq;
    } status_t;
endpackage

// File: rtl/sfs_byte_fifo.sv
// Byte queue with up to two pushes and two pops per clock.
// Pushes beyond the free space, and pops beyond the held count, are dropped.
// The push free-space check uses the level before any same-cycle pop.
// Flush empties the queue at the next clock and blocks all traffic.
// DEPTH must be a power of two, at least 2.
module sfs_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [1:0]          push_n,
    input  logic [1:0][DW-1:0]  din,
    input  logic [1:0]          pop_n,
    output logic [DW-1:0]       q0,
    output logic [DW-1:0]       q1,
    output logic [CW-1:0]       level,
    output logic                full,
    output logic                empty,
    output logic [1:0]          push_cnt,
    output logic [1:0]          pop_cnt
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt;
    logic [CW-1:0] free;

    // Limit requested pushes and pops to what the queue can serve.
    always_comb begin
        free = CW'(DEPTH) - cnt;
        if (flush) begin
            push_cnt = 2'd0;
            pop_cnt  = 2'd0;
        end else begin
            push_cnt = (CW'(push_n) > free) ? free[1:0] : push_n;
            pop_cnt  = (CW'(pop_n) > cnt) ? cnt[1:0] : pop_n;
        end
        wr_ptr = rd_ptr + PW'(cnt);
    end

    // Advance read pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            rd_ptr <= rd_ptr + PW'(pop_cnt);
            cnt    <= cnt + CW'(push_cnt) - CW'(pop_cnt);
        end
    end

    // Store accepted bytes at consecutive slots.
    always_ff @(posedge clk) begin
        for (int lane = 0; lane < 2; lane++) begin
            if (rst_n && (int'(push_cnt) > lane))
                mem[wr_ptr + PW'(lane)] <= din[lane];
        end
    end

    assign q0    = (cnt != '0) ? mem[rd_ptr] : '0;
    assign q1    = (cnt > CW'(1)) ? mem[rd_ptr + PW'(1)] : '0;
    assign level = cnt;
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));
endmodule

// File: rtl/sfs_irq_counter.sv
// Counts qualifying byte events and pulses `hit` on the event that
// brings the total to limit+1. The count then restarts from zero.
module sfs_irq_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    assign hit = ev && (cnt == limit);

    // Step on each event, restart on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (hit) cnt <= '0;
        else if (ev)  cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spi_fifo_stat.sv
// Register-side queues, status word and interrupt for an SPI peripheral.
// Read data is combinational in the cycle reg_rd is high. Read side
// effects (status clear, receive pop) take place at that clock edge.
// A flag set and a status read in the same clock leave the flag set.
module spi_fifo_stat
    import spi_fs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int ICW   = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_sel,
    input  logic [2*DW-1:0] wdata,
    output logic [2*DW-1:0] rdata,
    input  logic            dma_en,
    input  logic            rx_flush,
    input  logic            tx_flush,
    input  logic            irq_on_tx,
    input  logic [ICW-1:0]  irq_cnt,
    input  logic            eng_rx_push,
    input  logic [DW-1:0]   eng_rx_byte,
    input  logic            eng_tx_pop,
    output logic [DW-1:0]   eng_tx_byte,
    input  logic            eng_start,
    output logic            irq_o
);
    logic sts_rd, rx_rd, tx_wr;
    logic [1:0] rx_pop_req, tx_push_req;
    logic [DW-1:0] rx_q0, rx_q1, tx_q0, tx_q1;
    logic [CW-1:0] rx_lvl, tx_lvl;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic [1:0] rx_push_cnt, rx_pop_cnt, tx_push_cnt, tx_pop_cnt;
    logic ovf_ev, unf_ev, cnt_ev, cnt_hit, rx_irq_set, tx_irq_set, g_set;
    logic rx_ovf_q, rx_irq_q, tx_irq_q, tx_unf_q, g_q;
    status_t sts;
    logic unused_ok;

    // Decode bus strobes and per-access byte counts.
    always_comb begin
        sts_rd      = reg_rd && (reg_sel == SEL_STATUS);
        rx_rd       = reg_rd && (reg_sel == SEL_RXDATA);
        tx_wr       = reg_wr && (reg_sel == SEL_TXDATA);
        rx_pop_req  = rx_rd ? (dma_en ? 2'd2 : 2'd1) : 2'd0;
        tx_push_req = tx_wr ? (dma_en ? 2'd2 : 2'd1) : 2'd0;
    end

    sfs_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push_n({1'b0, eng_rx_push}), .din({{DW{1'b0}}, eng_rx_byte}),
        .pop_n(rx_pop_req), .q0(rx_q0), .q1(rx_q1), .level(rx_lvl),
        .full(rx_full), .empty(rx_empty),
        .push_cnt(rx_push_cnt), .pop_cnt(rx_pop_cnt)
    );

    sfs_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push_n(tx_push_req), .din({wdata[2*DW-1:DW], wdata[DW-1:0]}),
        .pop_n({1'b0, eng_tx_pop}), .q0(tx_q0), .q1(tx_q1), .level(tx_lvl),
        .full(tx_full), .empty(tx_empty),
        .push_cnt(tx_push_cnt), .pop_cnt(tx_pop_cnt)
    );

    // Select the byte-count event source; none in half-word mode.
    assign cnt_ev = !dma_en && (irq_on_tx ? (tx_pop_cnt != 2'd0)
                                          : (rx_push_cnt != 2'd0));

    sfs_irq_counter #(.CNT_W(ICW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ev(cnt_ev), .limit(irq_cnt), .hit(cnt_hit)
    );

    // Form the set terms for every sticky flag.
    always_comb begin
        ovf_ev     = eng_rx_push && rx_full;
        unf_ev     = eng_start && tx_empty;
        rx_irq_set = cnt_hit && !irq_on_tx;
        tx_irq_set = cnt_hit && irq_on_tx;
        g_set      = (ovf_ev && !rx_flush) || (unf_ev && !tx_flush)
                   || rx_irq_set || tx_irq_set;
    end

    // Sticky flags: set wins, otherwise cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ovf_q <= 1'b0;
            rx_irq_q <= 1'b0;
            tx_irq_q <= 1'b0;
            tx_unf_q <= 1'b0;
            g_q      <= 1'b0;
        end else begin
            rx_ovf_q <= ovf_ev     || (rx_ovf_q && !sts_rd);
            rx_irq_q <= rx_irq_set || (rx_irq_q && !sts_rd);
            tx_irq_q <= tx_irq_set || (tx_irq_q && !sts_rd);
            tx_unf_q <= unf_ev     || (tx_unf_q && !sts_rd);
            g_q      <= g_set      || (g_q && !sts_rd);
        end
    end

    // Assemble the status word.
    always_comb begin
        sts         = '0;
        sts.rx_lvl  = LVL_W'(rx_lvl);
        sts.rx_ovf  = rx_ovf_q;
        sts.rx_irq  = rx_irq_q;
        sts.tx_irq  = tx_irq_q;
        sts.tx_unf  = tx_unf_q;
        sts.tx_lvl  = LVL_W'(tx_lvl);
        sts.any_irq = g_q;
    end

    // Drive read data for the selected register.
    always_comb begin
        rdata = '0;
        if (reg_rd) begin
            case (reg_sel)
                SEL_STATUS: rdata = 16'(sts);
                SEL_RXDATA: rdata = dma_en ? {rx_q1, rx_q0} : {{DW{1'b0}}, rx_q0};
                default:    rdata = '0;
            endcase
        end
    end

    assign eng_tx_byte = tx_q0;
    assign irq_o       = g_q;
    assign unused_ok   = ^{tx_q1, rx_pop_cnt, tx_push_cnt, tx_full, rx_empty};

    p_overflow_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full) |=> rx_ovf_q);
    p_underflow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && tx_empty) |=> tx_unf_q);
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !g_set) |=> !irq_o);
    p_dma_no_count_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !rx_irq_q && !tx_irq_q) |=> !(rx_irq_q || tx_irq_q));
    p_irq_has_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (rx_ovf_q || rx_irq_q || tx_irq_q || tx_unf_q));
endmodule

// File: tb/spi_fifo_stat_tb.sv
module spi_fifo_stat_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_sel = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic dma_en = 0, rx_flush = 0, tx_flush = 0, irq_on_tx = 0;
    logic [1:0] irq_cnt = 0;
    logic eng_rx_push = 0, eng_tx_pop = 0, eng_start = 0;
    logic [7:0] eng_rx_byte = 0;
    logic [7:0] eng_tx_byte;
    logic irq_o;
    int n_chk = 0, n_fail = 0;
    logic [15:0] d;
    logic [7:0] b;

    always #10 clk = ~clk;

    spi_fifo_stat u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .dma_en(dma_en),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .irq_on_tx(irq_on_tx),
        .irq_cnt(irq_cnt), .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
        .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
        .eng_start(eng_start), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [15:0] v);
        reg_rd = 1; reg_sel = s;
        #2 v = rdata;
        @(negedge clk); reg_rd = 0;
    endtask
    task automatic bus_wr(input logic [1:0] s, input logic [15:0] v);
        reg_wr = 1; reg_sel = s; wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask
    task automatic rx_push(input logic [7:0] v);
        eng_rx_push = 1; eng_rx_byte = v;
        @(negedge clk); eng_rx_push = 0;
    endtask
    task automatic tx_pop(output logic [7:0] v);
        eng_tx_pop = 1;
        #2 v = eng_tx_byte;
        @(negedge clk); eng_tx_pop = 0;
    endtask
    task automatic start_xfer();
        eng_start = 1;
        @(negedge clk); eng_start = 0;
    endtask

    task automatic t_reset();
        check("R1 irq after reset", 16'(irq_o), 16'h0);
        bus_rd(2'd0, d); check("R1 status after reset", d, 16'h0000);
    endtask

    task automatic t_tx_byte_mode();
        for (int i = 1; i <= 5; i++) bus_wr(2'd2, 16'hFF00 | 16'(8'hA0 + i));
        bus_rd(2'd0, d); check("R2 tx level full", d, 16'h0008);
        for (int i = 1; i <= 4; i++) begin
            tx_pop(b); check("R2 tx order", 16'(b), 16'(8'hA0 + i));
        end
        bus_rd(2'd0, d); check("R2 tx drained", d, 16'h0000);
        start_xfer();
        check("R4 irq on underflow", 16'(irq_o), 16'h1);
        bus_rd(2'd0, d); check("R4 underflow status", d, 16'h0011);
        check("R8 irq cleared by read", 16'(irq_o), 16'h0);
        bus_rd(2'd0, d); check("R8 flags cleared", d, 16'h0000);
    endtask

    task automatic t_rx_count_overflow();
        irq_cnt = 2'd3; irq_on_tx = 0;
        for (int i = 0; i < 3; i++) rx_push(8'hB0 + 8'(i));
        check("R6 no irq before threshold", 16'(irq_o), 16'h0);
        bus_rd(2'd0, d); check("R6 rx level 3", d, 16'h0300);
        rx_push(8'hB3);
        check("R6 irq at threshold", 16'(irq_o), 16'h1);
        bus_rd(2'd0, d); check("R6 rx irq status", d, 16'h0441);
        rx_push(8'hB4);
        bus_rd(2'd0, d); check("R3 overflow status", d, 16'h0481);
        bus_rd(2'd1, d); check("R10 byte-mode read", d, 16'h00B0);
        bus_rd(2'd0, d); check("R8 level kept after clear", d, 16'h0300);
        for (int i = 1; i < 4; i++) begin
            bus_rd(2'd1, d); check("R3 stored order intact", d, 16'(8'hB0 + i));
        end
    endtask

    task automatic t_tx_count();
        irq_on_tx = 1; irq_cnt = 2'd1;
        for (int i = 0; i < 3; i++) bus_wr(2'd2, 16'(8'hC0 + i));
        tx_pop(b);
        check("R7 no irq after one pop", 16'(irq_o), 16'h0);
        tx_pop(b);
        check("R7 irq after two pops", 16'(irq_o), 16'h1);
        bus_rd(2'd0, d); check("R7 tx irq status", d, 16'h0023);
        tx_pop(b);
        bus_rd(2'd0, d); check("R7 count restarted", d, 16'h0000);
    endtask

    task automatic t_dma();
        dma_en = 1; irq_on_tx = 0; irq_cnt = 2'd0;
        bus_wr(2'd2, 16'hD2D1);
        tx_pop(b); check("R9 dma low byte first", 16'(b), 16'h00D1);
        tx_pop(b); check("R9 dma high byte second", 16'(b), 16'h00D2);
        rx_push(8'hE1); rx_push(8'hE2);
        check("R9 no count irq in dma", 16'(irq_o), 16'h0);
        bus_rd(2'd0, d); check("R9 rx level 2 no flags", d, 16'h0200);
        bus_rd(2'd1, d); check("R9 dma rx half-word", d, 16'hE2E1);
        bus_rd(2'd0, d); check("R9 both bytes removed", d, 16'h0000);
        dma_en = 0;
    endtask

    task automatic t_flush();
        irq_cnt = 2'd3;
        bus_wr(2'd2, 16'h0011); bus_wr(2'd2, 16'h0022);
        tx_flush = 1; @(negedge clk);
        bus_rd(2'd0, d); check("R5 tx flushed", d, 16'h0000);
        start_xfer();
        check("R5 underflow masked irq", 16'(irq_o), 16'h0);
        bus_rd(2'd0, d); check("R5 underflow flag only", d, 16'h0010);
        tx_flush = 0;
        rx_push(8'h55); rx_push(8'h66);
        rx_flush = 1; @(negedge clk); rx_flush = 0;
        bus_rd(2'd0, d); check("R5 rx flushed", d, 16'h0000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_tx_byte_mode();
                t_rx_count_overflow();
                t_tx_count();
                t_dma();
                t_flush();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule